// File: doc/BRIEF.md
# Inter-processor interrupt doorbell

This block is the doorbell a receiving processor uses to take interrupt requests from two peer processors. It holds a 32-bit pending word split into two fixed 16-bit groups: bits 15..0 are owned by the first peer and bits 31..16 by the second. A peer rings the bell by writing a one-hot word to the trigger register; the bit position is its group base (0 or 16) plus a source index it chooses. The receiver enables or disables each source through separate set-enable and clear-enable registers. It can read back both the pending word and the enable word. It acknowledges events by writing ones to a clear register.

A single level interrupt leaves the block. It is high while any pending bit is also enabled. The usual service routine reads the pending word and handles each nonzero 16-bit group. It then writes the exact value it read back to the clear register. Events that arrive between that read and the write-back therefore survive. A system builds one instance per receiving processor, and all instances share the same register layout.

Top module: `dbell_top`

## Requirements
- R1: After reset the pending word and the enable word read as zero, and `irq` and `rd_data` are low.
- R2: A write to offset 0x00 (trigger) sets every pending bit whose position is one in `wr_data`. Pending bits at zero positions keep their value. Bits 15..0 belong to the first peer and bits 31..16 to the second, so bit n of `wr_data` maps to pending bit n.
- R3: A write to offset 0x10 (clear) clears every pending bit whose position is one in `wr_data`. Other pending bits keep their value.
- R4: A read of offset 0x04 returns the full 32-bit pending word.
- R5: A write to offset 0x08 (set-enable) sets the matching enable bits, and zero bits have no effect. A read of offset 0x14 returns the enable word.
- R6: A write to offset 0x0C (clear-enable) clears the matching enable bits, and zero bits have no effect.
- R7: `irq` is registered. After each clock edge it equals the OR-reduction of (pending AND enable) as updated at that edge.
- R8: `rd_data` is registered. The edge that samples `addr` loads it with the selected register's value from before any write at that same edge. Reads of 0x00, 0x10 and any unmapped offset return zero. Writes to 0x04, 0x14 or an unmapped offset change nothing.
- R9: A trigger that lands after the receiver has read the pending word stays pending after the receiver writes the value it read to the clear register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for the offset sampled at the previous edge |
| irq | output | 1 | Interrupt to the receiving processor |

## Verification
The hardest situation to reach is the race in the service routine. A peer's trigger falls between the receiver's read of the pending word and its write-back to the clear register. The write-back must then remove only the events that were read. The bench builds this case directly. It triggers bits in one group and reads the pending word. Next it rings a bit in the other group, and also re-rings a bit that was already read. It then writes the read value to the clear register and checks that only the new bit remains pending and still drives `irq`. All 32 pending positions are swept one at a time through trigger, enable, disable and clear. Multi-bit patterns that overlap both groups then exercise the zero-bits-have-no-effect rules.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

  localparam int OFS_TRIG    = 'h00;
  localparam int OFS_RAW     = 'h04;
  localparam int OFS_EN_SET  = 'h08;
  localparam int OFS_EN_CLR  = 'h0C;
  localparam int OFS_ACK     = 'h10;
  localparam int OFS_EN_READ = 'h14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TRIG,
    SEL_RAW,
    SEL_EN_SET,
    SEL_EN_CLR,
    SEL_ACK,
    SEL_EN_READ
  } reg_sel_e;

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
  import dbell_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    sel = SEL_NONE;
    if      (addr == ADDR_W'(OFS_TRIG))    sel = SEL_TRIG;
    else if (addr == ADDR_W'(OFS_RAW))     sel = SEL_RAW;
    else if (addr == ADDR_W'(OFS_EN_SET))  sel = SEL_EN_SET;
    else if (addr == ADDR_W'(OFS_EN_CLR))  sel = SEL_EN_CLR;
    else if (addr == ADDR_W'(OFS_ACK))     sel = SEL_ACK;
    else if (addr == ADDR_W'(OFS_EN_READ)) sel = SEL_EN_READ;
  end

endmodule

// File: rtl/dbell_bitbank.sv
module dbell_bitbank #(
  parameter int W        = 32,
  parameter bit SET_WINS = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q,
  output logic [W-1:0] q_nxt
);

  generate
    if (SET_WINS) begin : g_set_wins
      assign q_nxt = (q & ~clr_vec) | set_vec;
    end else begin : g_clr_wins
      assign q_nxt = (q | set_vec) & ~clr_vec;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_nxt;
  end

  // R2 / R5: a set request leaves the bit high after the edge
  p_set_sticks_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((q & $past(set_vec & ~(SET_WINS ? '0 : clr_vec))) ==
              $past(set_vec & ~(SET_WINS ? '0 : clr_vec))));

  // R3 / R6: a clear request without a set leaves the bit low after the edge
  p_clear_drops_r3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((q & $past(clr_vec & ~set_vec)) == '0));

  // R2 / R3: bits not named by set or clear hold their value
  p_untouched_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (((q ^ $past(q)) & ~$past(set_vec | clr_vec)) == '0));

endmodule

// File: rtl/dbell_top.sv
module dbell_top
  import dbell_pkg::*;
#(
  parameter int GROUP_W = 16,
  parameter int GROUPS  = 2,
  parameter int ADDR_W  = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wr_en,
  input  logic [GROUP_W*GROUPS-1:0]  wr_data,
  output logic [GROUP_W*GROUPS-1:0]  rd_data,
  output logic                       irq
);

  localparam int DW = GROUP_W * GROUPS;

  reg_sel_e      sel;
  logic [DW-1:0] pend_q, pend_nxt;
  logic [DW-1:0] en_q, en_nxt;
  logic [DW-1:0] trig_vec, ack_vec, en_set_vec, en_clr_vec;
  logic [DW-1:0] rd_mux;

  dbell_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (addr),
    .sel  (sel)
  );

  assign trig_vec   = (wr_en && sel == SEL_TRIG)   ? wr_data : '0;
  assign ack_vec    = (wr_en && sel == SEL_ACK)    ? wr_data : '0;
  assign en_set_vec = (wr_en && sel == SEL_EN_SET) ? wr_data : '0;
  assign en_clr_vec = (wr_en && sel == SEL_EN_CLR) ? wr_data : '0;

  dbell_bitbank #(.W(DW), .SET_WINS(1'b1)) u_pending (
    .clk     (clk),
    .rst     (rst),
    .set_vec (trig_vec),
    .clr_vec (ack_vec),
    .q       (pend_q),
    .q_nxt   (pend_nxt)
  );

  dbell_bitbank #(.W(DW), .SET_WINS(1'b1)) u_enable (
    .clk     (clk),
    .rst     (rst),
    .set_vec (en_set_vec),
    .clr_vec (en_clr_vec),
    .q       (en_q),
    .q_nxt   (en_nxt)
  );

  always_comb begin
    case (sel)
      SEL_RAW:     rd_mux = pend_q;
      SEL_EN_READ: rd_mux = en_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      rd_data <= rd_mux;
      irq     <= |(pend_nxt & en_nxt);
    end
  end

  // R1: reset empties both words and silences the outputs
  p_reset_clean_r1: assert property (@(posedge clk)
    rst |=> (pend_q == '0 && en_q == '0 && !irq && rd_data == '0));

  // R7: interrupt tracks enabled pending state after every edge
  p_irq_level_r7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq == (|(pend_q & en_q))));

  // R8: write-only and unmapped offsets read as zero
  p_rd_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_TRIG || sel == SEL_ACK || sel == SEL_NONE) |=> (rd_data == '0));

  // R8: writes to read-only or unmapped offsets change no state
  p_ro_write_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (sel == SEL_RAW || sel == SEL_EN_READ || sel == SEL_NONE))
      |=> ($stable(pend_q) && $stable(en_q)));

endmodule

// File: tb/tb_dbell_top.sv
module tb_dbell_top;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [4:0]    addr;
  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic          irq;

  logic [DW-1:0] m_pend, m_en;
  int            n_checks = 0;
  int            n_fail   = 0;
  bit            done     = 1'b0;

  always #2 clk = ~clk;

  dbell_top dut (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq     (irq)
  );

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic write(input logic [4:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    case (a)
      5'h00: m_pend = m_pend | d;
      5'h10: m_pend = m_pend & ~d;
      5'h08: m_en   = m_en | d;
      5'h0C: m_en   = m_en & ~d;
      default: ;
    endcase
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic read(input logic [4:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
    check(rd_data, exp, tag);
  endtask

  task automatic check_irq(input string tag);
    check({31'd0, irq}, {31'd0, |(m_pend & m_en)}, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] seen;
    rst = 1'b1; addr = '0; wr_en = 1'b0; wr_data = '0;
    m_pend = '0; m_en = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rd_data, '0, "R1 rd_data after reset");
    check({31'd0, irq}, '0, "R1 irq after reset");
    rst = 1'b0;
    read(5'h04, '0, "R1 pending zero");
    read(5'h14, '0, "R1 enable zero");

    // single-bit sweep across both groups
    for (int g = 0; g < 2; g++) begin
      for (int idx = 0; idx < 16; idx++) begin
        logic [DW-1:0] b;
        b = DW'(1) << (g * 16 + idx);
        write(5'h00, b);
        check_irq("R7 irq low while disabled");
        read(5'h04, b, "R2 R4 one-hot trigger lands at group offset");
        write(5'h08, b);
        check_irq("R7 irq high once enabled");
        read(5'h14, b, "R5 enable readback");
        write(5'h0C, b);
        check_irq("R6 irq low after clear-enable");
        read(5'h14, '0, "R6 enable cleared");
        write(5'h10, b);
        read(5'h04, '0, "R3 clear removes bit");
      end
    end

    // multi-bit patterns
    write(5'h00, 32'hA5A5_0F0F);
    write(5'h00, 32'h0000_0000);
    read(5'h04, m_pend, "R2 zero trigger has no effect");
    write(5'h00, 32'h0101_1010);
    read(5'h04, 32'hA5A5_1F1F, "R2 trigger accumulates");
    write(5'h10, 32'h0F00_00FF);
    read(5'h04, 32'hA0A5_1F00, "R3 partial clear");
    write(5'h08, 32'h0000_00FF);
    check_irq("R7 enabled bits all cleared");
    write(5'h08, 32'hFFFF_FFFF);
    read(5'h14, 32'hFFFF_FFFF, "R5 enable all");
    check_irq("R7 irq with all enabled");
    write(5'h0C, 32'hFFFF_0000);
    read(5'h14, 32'h0000_FFFF, "R6 clear-enable upper group");
    check_irq("R7 irq from lower group");
    write(5'h08, 32'h0000_0000);
    read(5'h14, 32'h0000_FFFF, "R5 zero set-enable no effect");
    write(5'h0C, 32'h0000_0000);
    read(5'h14, 32'h0000_FFFF, "R6 zero clear-enable no effect");

    // read-only, write-only and unmapped offsets
    read(5'h00, '0, "R8 trigger reads zero");
    read(5'h10, '0, "R8 clear reads zero");
    read(5'h18, '0, "R8 unmapped reads zero");
    read(5'h01, '0, "R8 misaligned reads zero");
    write(5'h04, 32'hFFFF_FFFF);
    write(5'h14, 32'hFFFF_FFFF);
    write(5'h1C, 32'hFFFF_FFFF);
    read(5'h04, 32'hA0A5_1F00, "R8 pending unchanged by ro writes");
    read(5'h14, 32'h0000_FFFF, "R8 enable unchanged by ro writes");

    // read captures state before a same-edge write
    @(negedge clk);
    addr = 5'h04; wr_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    write(5'h00, 32'h0000_0001);
    check(rd_data, '0, "R8 trigger offset read during write");

    // service race: trigger between read and write-back
    write(5'h10, 32'hFFFF_FFFF);
    write(5'h08, 32'hFFFF_FFFF);
    write(5'h00, 32'h0000_0006);
    read(5'h04, 32'h0000_0006, "R9 receiver read");
    seen = 32'h0000_0006;
    write(5'h00, 32'h0004_0000);
    write(5'h00, 32'h0000_0002);
    write(5'h10, seen);
    read(5'h04, 32'h0004_0000, "R9 late trigger survives write-back");
    check_irq("R9 irq still raised by late trigger");
    write(5'h10, 32'h0004_0000);
    check_irq("R7 irq drops when empty");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule